// File: doc/BRIEF.md
# Virtual Address Region Classifier

This block sorts a 32-bit virtual address into one of the fixed regions of a 4-Gbyte address map and reports, one clock later, what the memory pipeline needs to know about that access: which region it hit, whether the current privilege level may touch it, whether the data may be cached, whether the address must go through the translation lookaside buffer, and the 29-bit physical address when the region maps straight through.

A requester presents an address with a valid strobe, a user/privileged flag and three control bits. The first control bit turns address translation on. The second closes the store-buffer window to user code. The third opens the on-chip scratch memory window to user code. The response fields are registered and stay stable until the next strobe. A separate response-valid pulse marks each new result. The lookup itself, the caches and exception sequencing are handled elsewhere.

Top module: `vaddr_region_classifier`

## Requirements
- R1: In privileged mode the region code is one-hot on the top three address bits. Bit 0 is set for addresses below 0x80000000. Bit 1 is set for 0x80000000..0x9FFFFFFF, bit 2 for 0xA0000000..0xBFFFFFFF, bit 3 for 0xC0000000..0xDFFFFFFF and bit 4 for 0xE0000000..0xFFFFFFFF. No privileged access raises an address error.
- R2: In user mode, addresses 0x00000000..0x7FFFFFFF are legal and report region bit 0.
- R3: In user mode the store-buffer window 0xE0000000..0xE3FFFFFF reports region bit 5 when the store-buffer block input is 0. When that input is 1, the window raises an address error.
- R4: In user mode the scratch window 0xE5000000..0xE5FFFFFF reports region bit 6 when the scratch enable input is 1. When that input is 0, the window raises an address error.
- R5: Every other user-mode address raises the address error. An address error forces the region code to all zeros and also forces the cacheable flag, the translation flag and the physical address to zero.
- R6: The needs-translation flag is 1 exactly when translation is enabled, no error is raised, and the region is bit 0 or bit 3.
- R7: When neither translation nor an error applies, the physical address equals the low 29 bits of the virtual address. Otherwise it is zero.
- R8: The cacheable flag is 1 for region bits 0, 1 and 3. It is 0 for bits 2, 4, 5 and 6, and it is 0 on error.
- R9: The response-valid output is 1 in the cycle after the cycle in which a strobe was sampled, and 0 otherwise. While no strobe arrives, all response fields hold their values.
- R10: While reset is asserted, response-valid and every response field are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Virtual address |
| req_user_i | input | 1 | 1 = user mode, 0 = privileged mode |
| xlate_en_i | input | 1 | Address translation enable |
| sq_user_block_i | input | 1 | 1 closes the store-buffer window to user mode |
| ocm_user_en_i | input | 1 | 1 opens the scratch window to user mode |
| rsp_valid_o | output | 1 | Response valid pulse |
| rsp_region_o | output | 7 | One-hot region code, all zeros on error |
| rsp_addr_err_o | output | 1 | Address error |
| rsp_cacheable_o | output | 1 | Cacheable access |
| rsp_xlate_o | output | 1 | Access needs translation |
| rsp_paddr_o | output | 29 | Physical address for directly mapped regions |

## Verification
The assertions assume that the request inputs are fully known (no X values) whenever the strobe is high, and that reset is released away from a rising edge. They also assume that the control bits are sampled together with the address, so a result depends only on the inputs of its own strobe cycle. The stimulus drives every input on the falling edge only, keeps the strobe low throughout reset, and inserts idle cycles in which the address and the control bits change while the strobe stays low. These idle cycles exercise the hold behaviour without breaking the one-request-per-strobe assumption.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 29;
  localparam int SEG_W = 3;
  localparam int NSEG  = 5;
  localparam int REG_W = NSEG + 2;

  localparam int RG_LOW  = 0;
  localparam int RG_DIRC = 1;
  localparam int RG_DIRU = 2;
  localparam int RG_MAPH = 3;
  localparam int RG_CTRL = 4;
  localparam int RG_SQ   = 5;
  localparam int RG_OCM  = 6;

  localparam int              SQ_PFX_W  = 6;
  localparam logic [SQ_PFX_W-1:0]  SQ_PFX  = 6'b111000;
  localparam int              OCM_PFX_W = 8;
  localparam logic [OCM_PFX_W-1:0] OCM_PFX = 8'hE5;

  typedef struct packed {
    logic [REG_W-1:0] region;
    logic             err;
    logic             cache;
    logic             xlate;
    logic [PA_W-1:0]  paddr;
  } vrc_rsp_t;
endpackage

// File: rtl/vrc_decode.sv
module vrc_decode
  import vrc_pkg::*;
#(
  parameter int ADDR_W = VA_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NSEG-1:0]   seg_oh_o,
  output logic              in_sq_o,
  output logic              in_ocm_o
);
  localparam int TOP = ADDR_W - 1;

  logic [SEG_W-1:0] seg_bits;
  assign seg_bits = addr_i[TOP -: SEG_W];

  assign seg_oh_o[0] = ~addr_i[TOP];

  for (genvar g = 1; g < NSEG; g++) begin : g_seg
    assign seg_oh_o[g] = (seg_bits == SEG_W'(3 + g));
  end

  assign in_sq_o  = (addr_i[TOP -: SQ_PFX_W]  == SQ_PFX);
  assign in_ocm_o = (addr_i[TOP -: OCM_PFX_W] == OCM_PFX);
endmodule

// File: rtl/vrc_legal.sv
module vrc_legal
  import vrc_pkg::*;
(
  input  logic [NSEG-1:0]  seg_oh_i,
  input  logic             in_sq_i,
  input  logic             in_ocm_i,
  input  logic             user_i,
  input  logic             sq_block_i,
  input  logic             ocm_en_i,
  output logic [REG_W-1:0] region_o,
  output logic             err_o
);
  always_comb begin
    region_o = '0;
    err_o    = 1'b0;
    if (!user_i) begin
      region_o[NSEG-1:0] = seg_oh_i;
    end else if (seg_oh_i[0]) begin
      region_o[RG_LOW] = 1'b1;
    end else if (in_sq_i && !sq_block_i) begin
      region_o[RG_SQ] = 1'b1;
    end else if (in_ocm_i && ocm_en_i) begin
      region_o[RG_OCM] = 1'b1;
    end else begin
      err_o = 1'b1;
    end
  end
endmodule

// File: rtl/vrc_attr.sv
module vrc_attr
  import vrc_pkg::*;
#(
  parameter int ADDR_W = VA_W,
  parameter int PHYS_W = PA_W
) (
  input  logic [REG_W-1:0]  region_i,
  input  logic              err_i,
  input  logic              xlate_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cache_o,
  output logic              xlate_o,
  output logic [PHYS_W-1:0] paddr_o
);
  logic mapped_area;
  assign mapped_area = region_i[RG_LOW] | region_i[RG_MAPH];

  always_comb begin
    xlate_o = xlate_en_i & mapped_area & ~err_i;
    cache_o = (region_i[RG_LOW] | region_i[RG_DIRC] | region_i[RG_MAPH]) & ~err_i;
    if (err_i || xlate_o) paddr_o = '0;
    else                  paddr_o = addr_i[PHYS_W-1:0];
  end
endmodule

// File: rtl/vaddr_region_classifier.sv
module vaddr_region_classifier
  import vrc_pkg::*;
#(
  parameter int ADDR_W = VA_W,
  parameter int PHYS_W = PA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                req_user_i,
  input  logic                xlate_en_i,
  input  logic                sq_user_block_i,
  input  logic                ocm_user_en_i,
  output logic                rsp_valid_o,
  output logic [REG_W-1:0]    rsp_region_o,
  output logic                rsp_addr_err_o,
  output logic                rsp_cacheable_o,
  output logic                rsp_xlate_o,
  output logic [PHYS_W-1:0]   rsp_paddr_o
);
  logic [NSEG-1:0]  seg_oh;
  logic             in_sq, in_ocm;
  logic [REG_W-1:0] region_d;
  logic             err_d, cache_d, xlate_d;
  logic [PHYS_W-1:0] paddr_d;

  vrc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i   (req_addr_i),
    .seg_oh_o (seg_oh),
    .in_sq_o  (in_sq),
    .in_ocm_o (in_ocm)
  );

  vrc_legal u_legal (
    .seg_oh_i   (seg_oh),
    .in_sq_i    (in_sq),
    .in_ocm_i   (in_ocm),
    .user_i     (req_user_i),
    .sq_block_i (sq_user_block_i),
    .ocm_en_i   (ocm_user_en_i),
    .region_o   (region_d),
    .err_o      (err_d)
  );

  vrc_attr #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_attr (
    .region_i   (region_d),
    .err_i      (err_d),
    .xlate_en_i (xlate_en_i),
    .addr_i     (req_addr_i),
    .cache_o    (cache_d),
    .xlate_o    (xlate_d),
    .paddr_o    (paddr_d)
  );

  // response register, loaded only on a strobe
  logic [REG_W-1:0]  region_q, region_n;
  logic              err_q, err_n, cache_q, cache_n, xlate_q, xlate_n;
  logic [PHYS_W-1:0] paddr_q, paddr_n;
  logic              valid_q, valid_n;

  always_comb begin
    valid_n  = req_valid_i;
    region_n = region_q;
    err_n    = err_q;
    cache_n  = cache_q;
    xlate_n  = xlate_q;
    paddr_n  = paddr_q;
    if (req_valid_i) begin
      region_n = region_d;
      err_n    = err_d;
      cache_n  = cache_d;
      xlate_n  = xlate_d;
      paddr_n  = paddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      region_q <= '0;
      err_q    <= 1'b0;
      cache_q  <= 1'b0;
      xlate_q  <= 1'b0;
      paddr_q  <= '0;
    end else begin
      valid_q  <= valid_n;
      region_q <= region_n;
      err_q    <= err_n;
      cache_q  <= cache_n;
      xlate_q  <= xlate_n;
      paddr_q  <= paddr_n;
    end
  end

  assign rsp_valid_o     = valid_q;
  assign rsp_region_o    = region_q;
  assign rsp_addr_err_o  = err_q;
  assign rsp_cacheable_o = cache_q;
  assign rsp_xlate_o     = xlate_q;
  assign rsp_paddr_o     = paddr_q;

  // ---------------- assertions ----------------
  assert_privileged_no_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_user_i) |=> (!rsp_addr_err_o && $onehot(rsp_region_o[NSEG-1:0])));

  assert_user_no_kernel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_user_i) |=> (rsp_region_o[RG_CTRL:RG_DIRC] == '0));

  assert_sq_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_user_i && sq_user_block_i) |=> !rsp_region_o[RG_SQ]);

  assert_ocm_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_user_i && !ocm_user_en_i) |=> !rsp_region_o[RG_OCM]);

  assert_err_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_addr_err_o |-> (rsp_region_o == '0 && !rsp_cacheable_o && !rsp_xlate_o
                        && rsp_paddr_o == '0));

  assert_region_or_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> ($countones({rsp_region_o, rsp_addr_err_o}) == 1));

  assert_xlate_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !xlate_en_i) |=> !rsp_xlate_o);

  assert_paddr_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_xlate_o && !rsp_addr_err_o)
      |-> rsp_paddr_o == $past(req_addr_i[PHYS_W-1:0]));

  assert_uncached_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_region_o[RG_DIRU] || rsp_region_o[RG_CTRL] || rsp_region_o[RG_SQ]
     || rsp_region_o[RG_OCM]) |-> !rsp_cacheable_o);

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);

  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> ($stable(rsp_region_o) && $stable(rsp_addr_err_o)
                      && $stable(rsp_cacheable_o) && $stable(rsp_xlate_o)
                      && $stable(rsp_paddr_o)));
endmodule

// File: tb/vaddr_region_classifier_tb.sv
module vaddr_region_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic [31:0] req_addr_i;
  logic        req_user_i, xlate_en_i, sq_user_block_i, ocm_user_en_i;
  logic        rsp_valid_o;
  logic [6:0]  rsp_region_o;
  logic        rsp_addr_err_o, rsp_cacheable_o, rsp_xlate_o;
  logic [28:0] rsp_paddr_o;

  always #5 clk = ~clk;

  vaddr_region_classifier u_dut (
    .clk, .rst_n, .req_valid_i, .req_addr_i, .req_user_i, .xlate_en_i,
    .sq_user_block_i, .ocm_user_en_i, .rsp_valid_o, .rsp_region_o,
    .rsp_addr_err_o, .rsp_cacheable_o, .rsp_xlate_o, .rsp_paddr_o
  );

  typedef struct {
    logic [6:0]  region;
    logic        err;
    logic        cache;
    logic        xlate;
    logic [28:0] paddr;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_last = 0;
  bit   done = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // independent reference built on numeric range comparisons
  function automatic exp_t ref_model(logic [31:0] a, bit user, bit xe, bit sqb, bit ocm);
    exp_t e;
    e.region = '0; e.err = 0; e.tag = "R1";
    if (!user) begin
      if      (a < 32'h8000_0000) e.region = 7'b000_0001;
      else if (a < 32'hA000_0000) e.region = 7'b000_0010;
      else if (a < 32'hC000_0000) e.region = 7'b000_0100;
      else if (a < 32'hE000_0000) e.region = 7'b000_1000;
      else                        e.region = 7'b001_0000;
    end else if (a <= 32'h7FFF_FFFF) begin
      e.region = 7'b000_0001; e.tag = "R2";
    end else if (a >= 32'hE000_0000 && a <= 32'hE3FF_FFFF) begin
      e.tag = "R3";
      if (!sqb) e.region = 7'b010_0000; else e.err = 1;
    end else if (a >= 32'hE500_0000 && a <= 32'hE5FF_FFFF) begin
      e.tag = "R4";
      if (ocm) e.region = 7'b100_0000; else e.err = 1;
    end else begin
      e.err = 1; e.tag = "R5";
    end
    e.xlate = !e.err && xe && (e.region[0] || e.region[3]);
    e.cache = e.region[0] || e.region[1] || e.region[3];
    e.paddr = (e.err || e.xlate) ? 29'd0 : a[28:0];
    return e;
  endfunction

  task automatic compare(exp_t e, string ctx);
    chk(rsp_region_o == e.region, e.tag, {ctx, " region"}, 32'(rsp_region_o), 32'(e.region));
    chk(rsp_addr_err_o == e.err, e.err ? "R5" : e.tag, {ctx, " addr_err"},
        32'(rsp_addr_err_o), 32'(e.err));
    chk(rsp_cacheable_o == e.cache, "R8", {ctx, " cacheable"}, 32'(rsp_cacheable_o), 32'(e.cache));
    chk(rsp_xlate_o == e.xlate, "R6", {ctx, " xlate"}, 32'(rsp_xlate_o), 32'(e.xlate));
    chk(rsp_paddr_o == e.paddr, "R7", {ctx, " paddr"}, 32'(rsp_paddr_o), 32'(e.paddr));
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (rsp_valid_o) begin
          if (q.size() == 0) begin
            chk(0, "R9", "response without request", 32'd1, 32'd0);
          end else begin
            last = q.pop_front();
            have_last = 1;
            compare(last, "resp");
          end
        end else if (have_last) begin
          compare(last, "R9 hold");
        end
      end
    end
  end

  task automatic send(logic [31:0] a, bit user, bit xe, bit sqb, bit ocm);
    req_valid_i = 1; req_addr_i = a; req_user_i = user;
    xlate_en_i = xe; sq_user_block_i = sqb; ocm_user_en_i = ocm;
    q.push_back(ref_model(a, user, xe, sqb, ocm));
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid_i = 0; req_addr_i = $urandom; req_user_i = 1'($urandom);
    xlate_en_i = 1'($urandom); sq_user_block_i = 1'($urandom); ocm_user_en_i = 1'($urandom);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "R9", "watchdog expired", 32'd0, 32'd1);
      finish_run();
    end
  end

  logic [31:0] bounds [16];
  initial begin
    bounds = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
               32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
               32'hE000_0000, 32'hE3FF_FFFF, 32'hE400_0000, 32'hE4FF_FFFF,
               32'hE500_0000, 32'hE5FF_FFFF, 32'hE600_0000, 32'hFFFF_FFFF};
    rst_n = 0; req_valid_i = 0; req_addr_i = '0; req_user_i = 0;
    xlate_en_i = 0; sq_user_block_i = 0; ocm_user_en_i = 0;
    repeat (3) @(negedge clk);
    // R10: reset state, with a strobe-free idle while reset is held
    chk(rsp_valid_o == 0, "R10", "reset valid", 32'(rsp_valid_o), 32'd0);
    chk(rsp_region_o == 0 && !rsp_addr_err_o && !rsp_cacheable_o && !rsp_xlate_o,
        "R10", "reset flags", 32'({rsp_region_o, rsp_addr_err_o, rsp_cacheable_o, rsp_xlate_o}), 32'd0);
    chk(rsp_paddr_o == 0, "R10", "reset paddr", 32'(rsp_paddr_o), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid_o == 0, "R9", "no pulse without strobe", 32'(rsp_valid_o), 32'd0);
    // boundary sweep over modes and control bit combinations
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        for (int b = 0; b < 16; b++) begin
          for (int d = -1; d <= 1; d++) begin
            send(bounds[b] + 32'(d), bit'(m), c[0], c[1], c[2]);
          end
          if ((b % 5) == 4) begin
            idle(); idle();
          end
        end
      end
    end
    idle(); idle(); idle();
    chk(q.size() == 0, "R9", "pending responses", 32'(q.size()), 32'd0);
    finish_run();
  end
endmodule